// File: doc/BRIEF.md
# Split Ripple Binary Counter

The block is a four-bit counter made of two sections with their own count inputs. A divide-by-two stage advances on each falling edge of `count_a` and drives `q[0]`. A binary divide-by-eight section advances on each falling edge of `count_b` and drives `q[3:1]`. Inside that section each bit toggles when the bit below it falls from 1 to 0. Used alone, the two sections act as independent frequency dividers. Joined, with the high section fed from the low stage's output, they form one modulo-16 binary counter.

The count inputs are treated as slow, asynchronous waveforms. Each one is synchronized into the `clk` domain, and its falling edges are detected there. Setting `cascade_en` routes the falling edge of `q[0]` into the high section inside the block, which is the same as wiring `q[0]` back to `count_b`. Two active-high clear inputs, `clr_a` and `clr_b`, act together. Only when both are high are all outputs forced to zero, and they stay at zero for as long as both remain high. The width of the high section is set by `HI_STAGES`, and the synchronizer depth by `SYNC_STAGES`.

Top module: `split_ripple_counter`

## Requirements
- R1: `q[0]` toggles exactly once for each falling edge of `count_a`, no more than SYNC_STAGES+2 clock cycles after the edge, and changes at no other time.
- R2: With `cascade_en` low, `q[3:1]` read as an unsigned number increase by one, modulo 8, for each falling edge of `count_b`, and `q[0]` is unaffected.
- R3: In the high section, `q[2]` toggles when `q[1]` goes from 1 to 0, and `q[3]` toggles when `q[2]` goes from 1 to 0.
- R4: With `cascade_en` high, `count_b` is ignored, and `q[3:0]` (q[0] least significant) count 0,1,2,…,15 in order, one step per falling edge of `count_a`.
- R5: In cascaded mode, the falling edge of `count_a` after the value 15 returns `q` to 0. No other output marks this wrap.
- R6: When `clr_a` and `clr_b` are both high, `q` reads 0 in the same cycle, with no clock edge needed. Count edges that occur while both are high are ignored, and `q` remains 0 once the clear is released.
- R7: When at least one of `clr_a` and `clr_b` is low (the combinations 00, 01 and 10), both sections count normally.
- R8: Driving `rst_n` low forces `q` to 0 at once, without a clock edge.
- R9: Rising edges on `count_a` and `count_b` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the count and clear inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_a | input | 1 | Count input of the divide-by-two stage; a falling edge advances it |
| count_b | input | 1 | Count input of the high section; used only when `cascade_en` is low |
| clr_a | input | 1 | First clear input; active only together with `clr_b` |
| clr_b | input | 1 | Second clear input; active only together with `clr_a` |
| cascade_en | input | 1 | 1: the high section is fed from the falling edge of `q[0]` |
| q | output | HI_STAGES+1 | Counter state; `q[0]` is the divide-by-two stage |

## Verification
The bench builds the block with its default values: `HI_STAGES` = 3 and `SYNC_STAGES` = 2. With these values the full 16-state sequence and its wrap are reached in about twenty pulses. The two-stage synchronizer is also what sets the response time the bench waits for after each pulse: four clocks after a falling edge. Because three high stages exist, the ripple from `q[1]` through `q[3]` is exercised, in both the standalone divide-by-eight mode and the cascaded mode.

// File: rtl/srbc_pkg.sv
package srbc_pkg;

  // falling edge seen between two consecutive samples
  function automatic logic is_fall(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // a toggling stage that currently holds 1 produces a 1->0 transition
  function automatic logic stage_falls(input logic tog, input logic cur_q, input logic clr);
    return tog & cur_q & ~clr;
  endfunction

endpackage

// File: rtl/srbc_edge.sv
module srbc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = srbc_pkg::is_fall(prev_q, sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/srbc_stage.sv
module srbc_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tog,
  output logic q_o,
  output logic fall_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= 1'b0;
    else if (clr) q_o <= 1'b0;
    else if (tog) q_o <= ~q_o;
  end

  assign fall_o = srbc_pkg::stage_falls(tog, q_o, clr);
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter #(
  parameter int HI_STAGES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 count_a,
  input  logic                 count_b,
  input  logic                 clr_a,
  input  logic                 clr_b,
  input  logic                 cascade_en,
  output logic [HI_STAGES:0]   q
);
  localparam int W = HI_STAGES + 1;

  logic             a_fall;
  logic             b_ext_fall;
  logic             b_evt;
  logic             clr_both;
  logic [W-1:0]     state;
  logic [W-1:0]     stage_fall;

  assign clr_both = clr_a & clr_b;

  srbc_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_a_i (
    .clk(clk), .rst_n(rst_n), .din(count_a), .fall_o(a_fall)
  );
  srbc_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_b_i (
    .clk(clk), .rst_n(rst_n), .din(count_b), .fall_o(b_ext_fall)
  );

  // divide-by-two section
  srbc_stage lo_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_both), .tog(a_fall),
    .q_o(state[0]), .fall_o(stage_fall[0])
  );

  // clock source of the high section
  assign b_evt = cascade_en ? stage_fall[0] : b_ext_fall;

  // high section: ripple chain, each stage clocked by the fall of the one below
  for (genvar g = 1; g < W; g++) begin : g_hi
    logic tog_in;
    if (g == 1) begin : g_first
      assign tog_in = b_evt;
    end else begin : g_next
      assign tog_in = stage_fall[g-1];
    end
    srbc_stage hi_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_both), .tog(tog_in),
      .q_o(state[g]), .fall_o(stage_fall[g])
    );
  end

  // clear acts on the outputs without waiting for a clock edge
  assign q = clr_both ? '0 : state;
endmodule

// File: rtl/srbc_checker.sv
module srbc_checker #(
  parameter int HI_STAGES = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_both,
  input logic               a_fall,
  input logic               b_evt,
  input logic               cascade_en,
  input logic [HI_STAGES:0] state
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_both |=> (state == '0)); // R6

  AST_LO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fall && !clr_both) |=> (state[0] != $past(state[0]))); // R1

  AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_fall && !clr_both) |=> $stable(state[0])); // R1

  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_evt && !clr_both) |=> $stable(state[HI_STAGES:1])); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && a_fall && !clr_both && state == '1) |=> (state == '0)); // R5

  if (HI_STAGES >= 2) begin : g_rip
    AST_RIPPLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(state[1]) && !$past(clr_both)) |-> (state[2] != $past(state[2]))); // R3
  end
endmodule

bind split_ripple_counter srbc_checker #(.HI_STAGES(HI_STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_both(clr_both), .a_fall(a_fall),
  .b_evt(b_evt), .cascade_en(cascade_en), .state(state)
);

// File: tb/split_ripple_counter_tb.sv
module split_ripple_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_a = 1'b0, count_b = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0;
  logic       cascade_en = 1'b0;
  logic [3:0] q;
  int         n_checks = 0, n_errors = 0;
  int         exp_cnt = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  split_ripple_counter dut_i (
    .clk(clk), .rst_n(rst_n), .count_a(count_a), .count_b(count_b),
    .clr_a(clr_a), .clr_b(clr_b), .cascade_en(cascade_en), .q(q)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) count_a = 1'b1;
    repeat (4) @(negedge clk);
    count_a = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) count_b = 1'b1;
    repeat (4) @(negedge clk);
    count_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    #1 check("R8 reset clears", int'(q), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_div2();
    cascade_en = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      pulse_a();
      check("R1 divide-by-two q0", int'(q[0]), i % 2);
      check("R2 high section untouched by A", int'(q[3:1]), 0);
    end
  endtask

  task automatic t_div8();
    do_reset();
    cascade_en = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      pulse_b();
      check("R2 divide-by-eight value", int'(q[3:1]), i % 8);
      check("R3 ripple bits", int'(q[3:2]), (i % 8) >> 1);
      check("R2 q0 untouched by B", int'(q[0]), 0);
    end
  endtask

  task automatic t_cascade();
    do_reset();
    cascade_en = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      pulse_a();
      if (i == 16) check("R5 wrap to zero", int'(q), 0);
      else         check("R4 cascaded count", int'(q), i % 16);
    end
    pulse_b();
    check("R4 count_b ignored when cascaded", int'(q), 4);
    exp_cnt = 4;
  endtask

  task automatic t_clear();
    cascade_en = 1'b1;
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b0; end
    pulse_a(); exp_cnt++;
    check("R7 clear 10 counts", int'(q), exp_cnt);
    @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b1; end
    pulse_a(); exp_cnt++;
    check("R7 clear 01 counts", int'(q), exp_cnt);
    @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    pulse_a(); exp_cnt++;
    check("R7 clear 00 counts", int'(q), exp_cnt);
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    #1 check("R6 clear 11 immediate", int'(q), 0);
    pulse_a();
    check("R6 edges ignored under clear", int'(q), 0);
    @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    repeat (2) @(negedge clk);
    check("R6 zero after release", int'(q), 0);
    pulse_a();
    check("R6 counts again after release", int'(q), 1);
  endtask

  task automatic t_rising();
    @(negedge clk) count_a = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 rising edge of A ignored", int'(q), 1);
    count_a = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 following fall counts", int'(q), 2);
    cascade_en = 1'b0;
    @(negedge clk) count_b = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 rising edge of B ignored", int'(q), 2);
    count_b = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 following fall of B counts", int'(q), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 state after reset", int'(q), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 idle after reset", int'(q), 0);
    t_div2();
    t_div8();
    t_cascade();
    t_clear();
    t_rising();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule